// File: doc/BRIEF.md
# Battle Core Instruction Executor

This block carries out one instruction of a two-operand, relative-addressed battle instruction set once an upstream stage has resolved both operands. The upstream stage hands over the instruction word, the address it was fetched from, and the two resolved operand values. For an operand in immediate mode the value is the data itself. For any other mode it is an absolute core address. The block reads what it needs from the core memory through a single synchronous read/write port. It performs any write-back the instruction calls for. In the same cycle as that write, it reports an outcome code and a target address to the process scheduler.

A core word holds a 4-bit opcode, two 2-bit addressing modes, and two address-wide operand fields. Moves, adds and subtracts act on a single field when the A operand is immediate and on the whole word otherwise. Compare, less-than, the two conditional jumps and decrement-and-jump select what the scheduler does next. Spawn asks for a new process, and halt-data removes the process that ran. All field arithmetic wraps modulo the core size of 2**AddrW words.

Top module: `core_exec_unit`

## Requirements
- R1: A `start` accepted while idle yields `done` high for exactly one cycle, three clock edges later. A `start` that arrives while an instruction is in flight is ignored.
- R2: Word layout from MSB to LSB: opcode[4], A-mode[2], B-mode[2], A-field[AddrW], B-field[AddrW]. Mode 0 means immediate. Opcodes are: 0 halt-data, 1 move, 2 add, 3 subtract, 4 jump, 5 jump-if-zero, 6 jump-if-nonzero, 7 compare, 8 less-than, 9 decrement-and-jump, 10 spawn. The all-zero word is therefore a halt-data instruction with both fields zero. Opcode 0 and the unused codes 11..15 report halt with target equal to the instruction address, and they write nothing.
- R3: A move with an immediate A replaces only the B-field of the word at the B address with the A value. With any other A mode, it copies the whole word at the A address to the B address.
- R4: An add or subtract with an immediate A changes only the B-field of the B word, by the A value. With any other A mode, it adds or subtracts both fields of the A word to or from the matching fields of the B word.
- R5: Jump reports jump, and spawn reports spawn. Both carry the A value as target and write nothing.
- R6: Jump-if-zero and jump-if-nonzero test the B operand's B-field, or the B value itself when B is immediate. They report jump to the A value when the test holds and next otherwise. They write nothing.
- R7: Compare with an immediate A tests the A value against the B operand's B-field. With any other A mode, it tests the whole A word against the whole B word. Equality reports skip, and a mismatch reports next. Compare writes nothing.
- R8: Less-than compares, unsigned, the A word's B-field (or the immediate A value) with the B operand's B-field. It reports skip when the A side is smaller and next otherwise. It writes nothing.
- R9: Decrement-and-jump decrements the B-field of the B word and writes that word back. When B is immediate, it instead decrements the B-field of the executing instruction and writes it back at the instruction's address. A nonzero result reports jump to the A value, and a zero result reports next.
- R10: Outcome codes are: 0 next (target = address+1), 1 skip (target = address+2), 2 jump, 3 spawn, 4 halt. All sums, differences, decrements and targets wrap modulo 2**AddrW, so a decrement of 0 gives 2**AddrW-1.
- R11: Any write-back is driven in the same cycle as `done`, and never in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the presented instruction |
| instrIn | input | 8+2*AddrW | Instruction word being executed |
| pcIn | input | AddrW | Core address of that instruction |
| aIn | input | AddrW | Resolved A operand: data if immediate, else an address |
| bIn | input | AddrW | Resolved B operand: data if immediate, else an address |
| memAddr | output | AddrW | Core port address |
| memWe | output | 1 | Core port write enable |
| memWdata | output | 8+2*AddrW | Core port write data |
| memRdata | input | 8+2*AddrW | Core port read data, one cycle after the address |
| done | output | 1 | Outcome valid this cycle |
| outcome | output | 3 | Scheduler outcome code |
| target | output | AddrW | Address that goes with the outcome |

## Verification
Two functions coincide in the final cycle: the core write-back and the outcome report to the scheduler. Every instruction is run to that cycle. The bench then checks the outcome code and target against a bench model, and in the following cycle compares the whole core with the model's copy. Any stray, missing or misplaced write shows up in that comparison. Cases where read and write addresses overlap are provoked on purpose: A equal to B, decrement-and-jump writing back to the instruction's own address, and random traffic in a small core. In those cases the bench confirms that the value written derives from the reads taken before the write.

// File: rtl/core_exec_pkg.sv
package core_exec_pkg;
  localparam logic [3:0] OP_HALT = 4'd0;
  localparam logic [3:0] OP_MOVE = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_JUMP = 4'd4;
  localparam logic [3:0] OP_JZ   = 4'd5;
  localparam logic [3:0] OP_JNZ  = 4'd6;
  localparam logic [3:0] OP_CMP  = 4'd7;
  localparam logic [3:0] OP_LT   = 4'd8;
  localparam logic [3:0] OP_DJ   = 4'd9;
  localparam logic [3:0] OP_SPAWN = 4'd10;

  localparam logic [2:0] OUT_NEXT  = 3'd0;
  localparam logic [2:0] OUT_SKIP  = 3'd1;
  localparam logic [2:0] OUT_JUMP  = 3'd2;
  localparam logic [2:0] OUT_SPAWN = 3'd3;
  localparam logic [2:0] OUT_HALT  = 3'd4;

  typedef struct packed {
    logic load;
    logic readA;
    logic readB;
    logic exec;
  } strobe_t;
endpackage

// File: rtl/core_exec_ctrl.sv
module core_exec_ctrl
  import core_exec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_RDA, S_RDB, S_EXE} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE: if (start) state <= S_RDA;
        S_RDA:  state <= S_RDB;
        S_RDB:  state <= S_EXE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load  = (state == S_IDLE) && start;
    stb.readA = (state == S_RDA);
    stb.readB = (state == S_RDB);
    stb.exec  = (state == S_EXE);
  end

  a_r1_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.readA, stb.readB, stb.exec}));
  a_r1_exec_after_start: assert property (@(posedge clk) disable iff (rst)
    stb.exec |-> $past(start, 3));
endmodule

// File: rtl/core_exec_datapath.sv
module core_exec_datapath
  import core_exec_pkg::*;
#(
  parameter int AddrW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              stb,
  input  logic [8+2*AddrW-1:0] instrIn,
  input  logic [AddrW-1:0]     pcIn,
  input  logic [AddrW-1:0]     aIn,
  input  logic [AddrW-1:0]     bIn,
  output logic [AddrW-1:0]     memAddr,
  output logic                 memWe,
  output logic [8+2*AddrW-1:0] memWdata,
  input  logic [8+2*AddrW-1:0] memRdata,
  output logic                 done,
  output logic [2:0]           outcome,
  output logic [AddrW-1:0]     target
);
  localparam int WordW = 8 + 2 * AddrW;
  localparam int FieldsW = 2 * AddrW;
  localparam logic [AddrW-1:0] One = AddrW'(1);
  localparam logic [AddrW-1:0] Two = AddrW'(2);

  logic [WordW-1:0] instrQ, aWordQ;
  logic [AddrW-1:0] pcQ, aValQ, bValQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      instrQ <= '0; aWordQ <= '0;
      pcQ <= '0; aValQ <= '0; bValQ <= '0;
    end else begin
      if (stb.load) begin
        instrQ <= instrIn; pcQ <= pcIn; aValQ <= aIn; bValQ <= bIn;
      end
      if (stb.readB) aWordQ <= memRdata;
    end
  end

  logic [3:0]       opQ;
  logic             aImm, bImm;
  logic [AddrW-1:0] aWordA, aWordB, bWordA, bWordB, instrB, bFieldOp;
  logic [WordW-1:0] bWord;

  always_comb begin
    opQ    = instrQ[WordW-1 -: 4];
    aImm   = (instrQ[FieldsW+3 -: 2] == 2'd0);
    bImm   = (instrQ[FieldsW+1 -: 2] == 2'd0);
    bWord  = memRdata;
    aWordA = aWordQ[FieldsW-1 -: AddrW];
    aWordB = aWordQ[AddrW-1:0];
    bWordA = bWord[FieldsW-1 -: AddrW];
    bWordB = bWord[AddrW-1:0];
    instrB = instrQ[AddrW-1:0];
    bFieldOp = bImm ? bValQ : bWordB;
  end

  logic             wrEn;
  logic [AddrW-1:0] wrAddr, decV, ltLeft;
  logic [WordW-1:0] wrData;
  logic [2:0]       outc;
  logic [AddrW-1:0] tgt;

  always_comb begin
    wrEn   = 1'b0;
    wrAddr = bValQ;
    wrData = bWord;
    outc   = OUT_NEXT;
    tgt    = pcQ + One;
    decV   = (bImm ? instrB : bWordB) - One;
    ltLeft = aImm ? aValQ : aWordB;
    case (opQ)
      OP_MOVE: begin
        wrEn = 1'b1;
        wrData = aImm ? {bWord[WordW-1:AddrW], aValQ} : aWordQ;
      end
      OP_ADD: begin
        wrEn = 1'b1;
        if (aImm) wrData = {bWord[WordW-1:AddrW], bWordB + aValQ};
        else      wrData = {bWord[WordW-1:FieldsW], bWordA + aWordA, bWordB + aWordB};
      end
      OP_SUB: begin
        wrEn = 1'b1;
        if (aImm) wrData = {bWord[WordW-1:AddrW], bWordB - aValQ};
        else      wrData = {bWord[WordW-1:FieldsW], bWordA - aWordA, bWordB - aWordB};
      end
      OP_JUMP: begin outc = OUT_JUMP; tgt = aValQ; end
      OP_JZ:   if (bFieldOp == '0) begin outc = OUT_JUMP; tgt = aValQ; end
      OP_JNZ:  if (bFieldOp != '0) begin outc = OUT_JUMP; tgt = aValQ; end
      OP_CMP: begin
        if (aImm ? (aValQ == bFieldOp) : (aWordQ == bWord)) begin
          outc = OUT_SKIP; tgt = pcQ + Two;
        end
      end
      OP_LT: begin
        if (ltLeft < bFieldOp) begin outc = OUT_SKIP; tgt = pcQ + Two; end
      end
      OP_DJ: begin
        wrEn   = 1'b1;
        wrAddr = bImm ? pcQ : bValQ;
        wrData = bImm ? {instrQ[WordW-1:AddrW], decV} : {bWord[WordW-1:AddrW], decV};
        if (decV != '0) begin outc = OUT_JUMP; tgt = aValQ; end
      end
      OP_SPAWN: begin outc = OUT_SPAWN; tgt = aValQ; end
      default: begin outc = OUT_HALT; tgt = pcQ; end
    endcase
  end

  always_comb begin
    done     = stb.exec;
    memWe    = stb.exec && wrEn;
    memWdata = wrData;
    outcome  = outc;
    target   = tgt;
    if (stb.exec)       memAddr = wrAddr;
    else if (stb.readB) memAddr = bValQ;
    else                memAddr = aValQ;
  end

  a_r2_halt_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && outcome == OUT_HALT) |-> !memWe);
  a_r7_skip_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && outcome == OUT_SKIP) |-> !memWe);
  a_r10_skip_target: assert property (@(posedge clk) disable iff (rst)
    (done && outcome == OUT_SKIP) |-> target == pcQ + Two);
  a_r11_write_with_done: assert property (@(posedge clk) disable iff (rst)
    memWe |-> done);
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/core_exec_unit.sv
module core_exec_unit
  import core_exec_pkg::*;
#(
  parameter int AddrW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [8+2*AddrW-1:0] instrIn,
  input  logic [AddrW-1:0]     pcIn,
  input  logic [AddrW-1:0]     aIn,
  input  logic [AddrW-1:0]     bIn,
  output logic [AddrW-1:0]     memAddr,
  output logic                 memWe,
  output logic [8+2*AddrW-1:0] memWdata,
  input  logic [8+2*AddrW-1:0] memRdata,
  output logic                 done,
  output logic [2:0]           outcome,
  output logic [AddrW-1:0]     target
);
  strobe_t stb;

  core_exec_ctrl u_ctrl (.clk(clk), .rst(rst), .start(start), .stb(stb));

  core_exec_datapath #(.AddrW(AddrW)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .instrIn(instrIn), .pcIn(pcIn), .aIn(aIn), .bIn(bIn),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .done(done), .outcome(outcome), .target(target)
  );
endmodule

// File: tb/core_exec_unit_tb.sv
module core_exec_unit_tb;
  localparam int AW = 6;
  localparam int WW = 8 + 2 * AW;
  localparam int M = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [WW-1:0] instrIn = '0;
  logic [AW-1:0] pcIn = '0, aIn = '0, bIn = '0;
  logic [AW-1:0] memAddr;
  logic memWe, done;
  logic [WW-1:0] memWdata;
  logic [WW-1:0] memRdata = '0;
  logic [2:0] outcome;
  logic [AW-1:0] target;

  int errors = 0;
  int checks = 0;

  logic [WW-1:0] mem [M];
  logic [WW-1:0] expMem [M];

  always #2.5 clk = ~clk;

  core_exec_unit #(.AddrW(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .instrIn(instrIn), .pcIn(pcIn),
    .aIn(aIn), .bIn(bIn), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .done(done), .outcome(outcome), .target(target)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(input int op, input int ma, input int mb,
                                       input int fa, input int fb);
    return {op[3:0], ma[1:0], mb[1:0], fa[AW-1:0], fb[AW-1:0]};
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      1: return "R3"; 2, 3: return "R4"; 4, 10: return "R5"; 5, 6: return "R6";
      7: return "R7"; 8: return "R8"; 9: return "R9"; default: return "R2";
    endcase
  endfunction

  // Reference model: updates expMem, returns outcome and target.
  task automatic model(input logic [WW-1:0] ins, input int pc, input int av, input int bv,
                       output int oc, output int tg);
    int op, fa, fb, wa, wb, ia, ib, bf, d;
    bit ai, bi;
    logic [WW-1:0] aw, bw;
    op = int'(ins[WW-1 -: 4]);
    ai = (ins[2*AW+3 -: 2] == 0);
    bi = (ins[2*AW+1 -: 2] == 0);
    aw = expMem[av]; bw = expMem[bv];
    ia = int'(aw[2*AW-1 -: AW]); ib = int'(aw[AW-1:0]);
    wa = int'(bw[2*AW-1 -: AW]); wb = int'(bw[AW-1:0]);
    bf = bi ? bv : wb;
    oc = 0; tg = (pc + 1) % M;
    case (op)
      1: if (ai) expMem[bv] = {bw[WW-1:AW], av[AW-1:0]}; else expMem[bv] = aw;
      2: begin
        if (ai) fb = (wb + av) % M;
        else begin fa = (wa + ia) % M; fb = (wb + ib) % M; end
        if (ai) expMem[bv] = {bw[WW-1:AW], fb[AW-1:0]};
        else expMem[bv] = {bw[WW-1:2*AW], fa[AW-1:0], fb[AW-1:0]};
      end
      3: begin
        if (ai) fb = (wb - av + M) % M;
        else begin fa = (wa - ia + M) % M; fb = (wb - ib + M) % M; end
        if (ai) expMem[bv] = {bw[WW-1:AW], fb[AW-1:0]};
        else expMem[bv] = {bw[WW-1:2*AW], fa[AW-1:0], fb[AW-1:0]};
      end
      4: begin oc = 2; tg = av; end
      5: if (bf == 0) begin oc = 2; tg = av; end
      6: if (bf != 0) begin oc = 2; tg = av; end
      7: if (ai ? (av == bf) : (aw == bw)) begin oc = 1; tg = (pc + 2) % M; end
      8: if ((ai ? av : ib) < bf) begin oc = 1; tg = (pc + 2) % M; end
      9: begin
        if (bi) begin
          d = (int'(ins[AW-1:0]) + M - 1) % M;
          expMem[pc] = {ins[WW-1:AW], d[AW-1:0]};
        end else begin
          d = (wb + M - 1) % M;
          expMem[bv] = {bw[WW-1:AW], d[AW-1:0]};
        end
        if (d != 0) begin oc = 2; tg = av; end
      end
      10: begin oc = 3; tg = av; end
      default: begin oc = 4; tg = pc; end
    endcase
  endtask

  task automatic runOp(input logic [WW-1:0] ins, input int pc, input int av, input int bv,
                       input bit busyPoke);
    int eo, et, bad;
    string rq;
    rq = reqOf(int'(ins[WW-1 -: 4]));
    model(ins, pc, av, bv, eo, et);
    @(negedge clk);
    start = 1'b1; instrIn = ins; pcIn = pc[AW-1:0]; aIn = av[AW-1:0]; bIn = bv[AW-1:0];
    @(posedge clk);
    @(negedge clk);
    if (busyPoke) begin
      instrIn = mk(4, 1, 1, 5, 5); aIn = 7;  // R1: start while busy must be ignored
    end else start = 1'b0;
    check(!done, "R1", "done early", done, 0);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(done, "R1", "done at third edge", done, 1);
    check(outcome == eo[2:0], rq, "outcome", outcome, eo);
    check(target == et[AW-1:0], "R10", "target", target, et);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R1", "done single cycle", done, 0);
    bad = 0;
    for (int i = 0; i < M; i++) if (mem[i] !== expMem[i]) bad++;
    check(bad == 0, (rq == "R2" || rq == "R5" || rq == "R6" || rq == "R7" || rq == "R8")
          ? "R11" : rq, "core words differing", bad, 0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd13579));
    for (int i = 0; i < M; i++) begin mem[i] = '0; expMem[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !memWe, "R2", "reset outputs quiet", {done, memWe}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !memWe, "R2", "idle outputs quiet", {done, memWe}, 0);

    // R2: all-zero core word executes as halt
    runOp(mem[12], 12, 0, 0, 1'b0);
    // R2: unused opcode behaves as halt
    runOp(mk(13, 1, 1, 3, 4), 20, 3, 4, 1'b0);

    for (int i = 0; i < M; i++) begin
      mem[i] = WW'($urandom) & {4'h0, {(WW-4){1'b1}}};
      mem[i][WW-1 -: 4] = 4'($urandom_range(0, 10));
      expMem[i] = mem[i];
    end
    // R3: immediate move touches only B-field; whole-word move
    runOp(mk(1, 0, 1, 9, 0), 5, 9, 30, 1'b0);
    runOp(mk(1, 1, 1, 0, 0), 5, 40, 41, 1'b0);
    // R4: add/sub wrap
    runOp(mk(2, 0, 1, 0, 0), 3, 63, 44, 1'b0);
    runOp(mk(3, 1, 1, 0, 0), 3, 45, 45, 1'b0);
    // R9: immediate-B decrement at its own address, wrapping through zero
    runOp(mk(9, 1, 0, 17, 0), 50, 17, 0, 1'b0);
    mem[51] = mk(0, 0, 0, 0, 1); expMem[51] = mem[51];
    runOp(mk(9, 1, 1, 2, 0), 60, 2, 51, 1'b0);
    // R7: equal whole words skip (same address), target wraps
    runOp(mk(7, 1, 1, 0, 0), 63, 33, 33, 1'b0);
    // R8: immediate less-than
    mem[22][AW-1:0] = 6'd10; expMem[22] = mem[22];
    runOp(mk(8, 0, 1, 9, 0), 62, 9, 22, 1'b0);
    runOp(mk(8, 0, 1, 10, 0), 62, 10, 22, 1'b0);
    // R6: immediate-B zero test
    runOp(mk(5, 1, 0, 0, 0), 8, 31, 0, 1'b0);
    runOp(mk(6, 1, 0, 0, 0), 8, 31, 0, 1'b0);
    // R5 with R1 busy poke
    runOp(mk(10, 1, 1, 0, 0), 8, 19, 2, 1'b1);
    runOp(mk(4, 1, 1, 0, 0), 8, 27, 2, 1'b1);

    for (int n = 0; n < 400; n++) begin
      logic [WW-1:0] ins;
      int pc, av, bv;
      ins = mk($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3),
               $urandom_range(0, M-1), $urandom_range(0, M-1));
      pc = $urandom_range(0, M-1);
      av = $urandom_range(0, 3) == 0 ? pc : $urandom_range(0, M-1);
      bv = $urandom_range(0, 3) == 0 ? av : $urandom_range(0, M-1);
      runOp(ins, pc, av, bv, n[2]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule